// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Data-Ready and Limit Alarm

This block schedules conversions for a 16-input sampling converter. In direct mode, a falling edge on the active-low trigger input converts one selected channel. In auto mode, the block loops without pause over a list of enabled scan slots. Each slot takes one conversion of fixed length, and disabled slots are passed over at no cost in time. The converter is modelled as a fixed-latency interface. The block names the slot and marks the start of each conversion, then samples the returned code on the conversion's last cycle.

Inputs 0 and 1 can be merged into one differential slot, and inputs 2 and 3 into another. A merged pair lives in the slot of its lower input. Its partner is never scanned, and its result is stored as two's complement. Every result goes into a per-slot register and is checked against a per-slot window. A window violation sets a sticky status bit, and the enabled status bits drive an active-low alarm. An active-low data-available output reports results. In direct mode it is a level that holds until it is serviced. In auto mode it is a fixed-width pulse at the end of each full scan.

Top module: `adc_scan_seq`

## Requirements
- R1: In direct mode, a high-to-low transition of `cnvt_ni` that holds for at least one clock sample starts a conversion two clock edges later, with `conv_start_o` high for that one cycle. The result is written CONV_CYC edges after the start edge.
- R2: A trigger edge is ignored while a conversion is in progress, and ignored at all in auto mode.
- R3: In direct mode, `dav_no` goes low on the edge that writes the result. It stays low until a read (`rd_en_i`) or the start of a new conversion sets it high.
- R4: In auto mode, enabled slots are converted in ascending index order, back to back, each taking CONV_CYC cycles. Disabled slots cost no cycles. After the highest enabled slot, the scan wraps to the lowest.
- R5: In auto mode, `dav_no` goes low for exactly DAV_PULSE_CYC cycles, starting on the edge that writes the highest enabled slot. It is high otherwise.
- R6: When `diff_en_i[0]` is set, inputs 0 and 1 form one differential slot at index 0. When `diff_en_i[1]` is set, inputs 2 and 3 form one at index 2. The partner index (1 or 3) is never scanned. A direct select of either input of a pair converts the pair's slot. `conv_diff_o` is high exactly while a pair is converted.
- R7: The converter returns differential codes in offset binary, where 0x800 means zero. A differential result is stored with its MSB inverted, which gives two's complement. Single-ended codes are stored unchanged.
- R8: A result above the slot's upper limit or below its lower limit sets that slot's status bit. A result equal to a limit does not. The comparison is signed for a differential slot and unsigned otherwise. Limits for slot k sit in bits [12k+11:12k] of `hi_lim_i` and `lo_lim_i`.
- R9: A status bit stays set until its `alarm_clr_i` bit is high at a clock edge. A new violation on the same edge keeps it set.
- R10: `alarm_no` is low exactly when some status bit is set and its `alarm_en_i` bit is high.
- R11: `rd_data_o` holds the stored result of slot `rd_ch_i` from the edge that samples `rd_en_i` high.
- R12: After reset, all results and status bits are zero, `dav_no` and `alarm_no` are high, and `conv_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_auto_i | input | 1 | 1 selects auto scan, 0 selects direct mode |
| cnvt_ni | input | 1 | Conversion trigger, falling-edge active |
| dir_sel_i | input | 4 | Input converted in direct mode |
| ch_en_i | input | 16 | Slot enables for auto scan |
| diff_en_i | input | 2 | Bit 0 merges inputs 0/1, bit 1 merges inputs 2/3 |
| conv_start_o | output | 1 | One-cycle mark of a conversion start |
| conv_ch_o | output | 4 | Slot under conversion |
| conv_diff_o | output | 1 | Current slot is a differential pair |
| adc_data_i | input | 12 | Code returned by the converter |
| rd_en_i | input | 1 | Read strobe |
| rd_ch_i | input | 4 | Slot to read |
| rd_data_o | output | 12 | Read result |
| hi_lim_i | input | 192 | Upper limits, 12 bits per slot |
| lo_lim_i | input | 192 | Lower limits, 12 bits per slot |
| alarm_en_i | input | 16 | Status bits that may drive the alarm |
| alarm_clr_i | input | 16 | Clears the matching status bits |
| alarm_sts_o | output | 16 | Sticky violation status |
| dav_no | output | 1 | Data available, active low |
| alarm_no | output | 1 | Global alarm, active low |

## Verification
A direct trigger applied before edge 1 gives `conv_start_o` after edge 2. `dav_no` is still high after edge 9 and goes low after edge 10 (CONV_CYC=8). A read gives data after the next edge. The bench counts negative edges from each stimulus and samples at exactly those points, one cycle before and on the due edge. In auto mode, the slot changes after edges 1, 9 and 17, and so on. The end-of-scan pulse is sampled low for four consecutive cycles and high on either side. Status and alarm are checked in the cycle after the write edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DEF_CH_N  = 16;
  localparam int DEF_RES_W = 12;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DIRECT = 2'd1,
    SRC_AUTO   = 2'd2
  } start_src_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_ni,
  output logic fall_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= trig_ni;
      s2_q <= s1_q;
    end
  end

  assign fall_o = s2_q & ~s1_q;
endmodule

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
  parameter int CH_N  = 16,
  parameter int IDX_W = 4
) (
  input  logic [CH_N-1:0]  en_i,
  input  logic [IDX_W-1:0] cur_i,
  output logic [IDX_W-1:0] first_o,
  output logic [IDX_W-1:0] next_o,
  output logic             wrap_o,
  output logic             any_o
);
  // lowest enabled slot overall, and lowest enabled slot above cur_i
  always_comb begin
    first_o = '0;
    any_o   = 1'b0;
    for (int k = CH_N - 1; k >= 0; k--) begin
      if (en_i[k]) begin
        first_o = IDX_W'(k);
        any_o   = 1'b1;
      end
    end
    next_o = first_o;
    wrap_o = 1'b1;
    for (int k = CH_N - 1; k >= 0; k--) begin
      if (en_i[k] && (k > int'(cur_i))) begin
        next_o = IDX_W'(k);
        wrap_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_limit_bank.sv
module adc_limit_bank #(
  parameter int CH_N  = 16,
  parameter int RES_W = 12,
  parameter int IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      wr_slot_i,
  input  logic [RES_W-1:0]      wr_val_i,
  input  logic                  wr_signed_i,
  input  logic [CH_N*RES_W-1:0] hi_lim_i,
  input  logic [CH_N*RES_W-1:0] lo_lim_i,
  input  logic [CH_N-1:0]       clr_i,
  input  logic                  rd_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [RES_W-1:0]      rd_data_o,
  output logic [CH_N-1:0]       sts_o
);
  logic [RES_W-1:0] res_q [CH_N];
  logic [RES_W-1:0] hi_sel, lo_sel;
  logic             viol;
  logic [CH_N-1:0]  set_vec, sts_q;

  assign hi_sel = hi_lim_i[wr_slot_i*RES_W +: RES_W];
  assign lo_sel = lo_lim_i[wr_slot_i*RES_W +: RES_W];

  always_comb begin
    if (wr_signed_i)
      viol = ($signed(wr_val_i) > $signed(hi_sel)) || ($signed(wr_val_i) < $signed(lo_sel));
    else
      viol = (wr_val_i > hi_sel) || (wr_val_i < lo_sel);
    set_vec = '0;
    if (wr_i && viol) set_vec[wr_slot_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < CH_N; k++) res_q[k] <= '0;
      rd_data_o <= '0;
      sts_q     <= '0;
    end else begin
      if (wr_i) res_q[wr_slot_i] <= wr_val_i;
      if (rd_i) rd_data_o <= res_q[rd_idx_i];
      sts_q <= (sts_q & ~clr_i) | set_vec;
    end
  end

  assign sts_o = sts_q;

  // a status bit only rises on an edge that wrote a result
  p_sts_set_by_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_q & ~$past(sts_q))) |-> $past(wr_i));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_N          = DEF_CH_N,
  parameter int RES_W         = DEF_RES_W,
  parameter int CONV_CYC      = 8,
  parameter int DAV_PULSE_CYC = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mode_auto_i,
  input  logic                      cnvt_ni,
  input  logic [$clog2(CH_N)-1:0]   dir_sel_i,
  input  logic [CH_N-1:0]           ch_en_i,
  input  logic [1:0]                diff_en_i,
  output logic                      conv_start_o,
  output logic [$clog2(CH_N)-1:0]   conv_ch_o,
  output logic                      conv_diff_o,
  input  logic [RES_W-1:0]          adc_data_i,
  input  logic                      rd_en_i,
  input  logic [$clog2(CH_N)-1:0]   rd_ch_i,
  output logic [RES_W-1:0]          rd_data_o,
  input  logic [CH_N*RES_W-1:0]     hi_lim_i,
  input  logic [CH_N*RES_W-1:0]     lo_lim_i,
  input  logic [CH_N-1:0]           alarm_en_i,
  input  logic [CH_N-1:0]           alarm_clr_i,
  output logic [CH_N-1:0]           alarm_sts_o,
  output logic                      dav_no,
  output logic                      alarm_no
);
  localparam int IDX_W = $clog2(CH_N);
  localparam int CNT_W = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam int PW    = $clog2(DAV_PULSE_CYC + 1);

  logic             trig_fall;
  logic [CH_N-1:0]  slot_en;
  logic [IDX_W-1:0] dir_slot, first_slot, next_slot, start_slot;
  logic             wrap, any_en, last_conv, start_diff;
  start_src_e       src;

  logic             busy_q, auto_q, diff_q, start_q, dav_lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] cur_q;
  logic [PW-1:0]    pulse_q;
  logic [RES_W-1:0] wr_val;

  adc_trig_sync u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_ni (cnvt_ni),
    .fall_o  (trig_fall)
  );

  // partner inputs of a merged pair drop out of the scan
  always_comb begin
    slot_en = ch_en_i;
    if (diff_en_i[0]) slot_en[1] = 1'b0;
    if (diff_en_i[1]) slot_en[3] = 1'b0;
    dir_slot = dir_sel_i;
    if (diff_en_i[0] && dir_sel_i == IDX_W'(1)) dir_slot = IDX_W'(0);
    if (diff_en_i[1] && dir_sel_i == IDX_W'(3)) dir_slot = IDX_W'(2);
  end

  adc_scan_pick #(.CH_N(CH_N), .IDX_W(IDX_W)) u_pick (
    .en_i    (slot_en),
    .cur_i   (cur_q),
    .first_o (first_slot),
    .next_o  (next_slot),
    .wrap_o  (wrap),
    .any_o   (any_en)
  );

  assign last_conv = busy_q && (cnt_q == CNT_W'(CONV_CYC - 1));

  always_comb begin
    src        = SRC_NONE;
    start_slot = '0;
    if (last_conv && auto_q && mode_auto_i && any_en) begin
      src        = SRC_AUTO;
      start_slot = next_slot;
    end else if (!busy_q && mode_auto_i && any_en) begin
      src        = SRC_AUTO;
      start_slot = first_slot;
    end else if (!busy_q && !mode_auto_i && trig_fall) begin
      src        = SRC_DIRECT;
      start_slot = dir_slot;
    end
    start_diff = (start_slot == IDX_W'(0) && diff_en_i[0]) ||
                 (start_slot == IDX_W'(2) && diff_en_i[1]);
  end

  // offset binary to two's complement for pairs
  assign wr_val = diff_q ? {~adc_data_i[RES_W-1], adc_data_i[RES_W-2:0]} : adc_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      auto_q    <= 1'b0;
      diff_q    <= 1'b0;
      start_q   <= 1'b0;
      cnt_q     <= '0;
      cur_q     <= '0;
      dav_lvl_q <= 1'b0;
      pulse_q   <= '0;
    end else begin
      start_q <= (src != SRC_NONE);
      if (src != SRC_NONE) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        cur_q  <= start_slot;
        diff_q <= start_diff;
        auto_q <= (src == SRC_AUTO);
      end else if (last_conv) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end

      if (src == SRC_DIRECT)         dav_lvl_q <= 1'b0;
      else if (last_conv && !auto_q) dav_lvl_q <= 1'b1;
      else if (rd_en_i)              dav_lvl_q <= 1'b0;

      if (last_conv && auto_q && wrap) pulse_q <= PW'(DAV_PULSE_CYC);
      else if (pulse_q != '0)          pulse_q <= pulse_q - 1'b1;
    end
  end

  adc_limit_bank #(.CH_N(CH_N), .RES_W(RES_W), .IDX_W(IDX_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (last_conv),
    .wr_slot_i   (cur_q),
    .wr_val_i    (wr_val),
    .wr_signed_i (diff_q),
    .hi_lim_i    (hi_lim_i),
    .lo_lim_i    (lo_lim_i),
    .clr_i       (alarm_clr_i),
    .rd_i        (rd_en_i),
    .rd_idx_i    (rd_ch_i),
    .rd_data_o   (rd_data_o),
    .sts_o       (alarm_sts_o)
  );

  assign conv_start_o = start_q;
  assign conv_ch_o    = cur_q;
  assign conv_diff_o  = diff_q;
  assign dav_no       = ~(dav_lvl_q | (pulse_q != '0));
  assign alarm_no     = ~|(alarm_sts_o & alarm_en_i);

  p_start_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_ch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_start_o) |-> $stable(conv_ch_o));

  p_pick_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |-> slot_en[next_slot]);

  p_dav_after_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dav_no) |-> $past(last_conv));

  p_diff_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_diff_o |-> (conv_ch_o == IDX_W'(0) || conv_ch_o == IDX_W'(2)));
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CH_N  = 16;
  localparam int RES_W = 12;

  // {sel[4], diff[2], raw[12], slot[4], stored[12]}
  localparam logic [33:0] VEC [7] = '{
    {4'd0,  2'b00, 12'h123, 4'd0,  12'h123},
    {4'd7,  2'b00, 12'hABC, 4'd7,  12'hABC},
    {4'd15, 2'b00, 12'hFFF, 4'd15, 12'hFFF},
    {4'd1,  2'b01, 12'h800, 4'd0,  12'h000},
    {4'd3,  2'b10, 12'h000, 4'd2,  12'h800},
    {4'd2,  2'b10, 12'h7FF, 4'd2,  12'hFFF},
    {4'd1,  2'b00, 12'h456, 4'd1,  12'h456}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_auto = 1'b0, cnvt_n = 1'b1, conv_start, conv_diff, rd_en = 1'b0;
  logic [3:0] dir_sel = '0, conv_ch, rd_ch = '0;
  logic [CH_N-1:0] ch_en = '0, alarm_en = '0, alarm_clr = '0, alarm_sts;
  logic [1:0] diff_en = '0;
  logic [RES_W-1:0] adc_data, rd_data;
  logic [CH_N*RES_W-1:0] hi_lim, lo_lim;
  logic dav_n, alarm_n;
  logic [RES_W-1:0] model_raw [CH_N];
  logic [RES_W-1:0] got;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign adc_data = model_raw[conv_ch];

  adc_scan_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_auto_i(mode_auto), .cnvt_ni(cnvt_n),
    .dir_sel_i(dir_sel), .ch_en_i(ch_en), .diff_en_i(diff_en),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch), .conv_diff_o(conv_diff),
    .adc_data_i(adc_data), .rd_en_i(rd_en), .rd_ch_i(rd_ch), .rd_data_o(rd_data),
    .hi_lim_i(hi_lim), .lo_lim_i(lo_lim), .alarm_en_i(alarm_en),
    .alarm_clr_i(alarm_clr), .alarm_sts_o(alarm_sts), .dav_no(dav_n), .alarm_no(alarm_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // trigger at a negedge; result written on the 10th posedge after it
  task automatic run_direct(input logic [3:0] sel, input logic [3:0] slot, input logic dif);
    @(negedge clk); dir_sel = sel; cnvt_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 start mark", conv_start, 1);
    chk("R6 slot", conv_ch, slot);
    chk("R6 diff flag", conv_diff, dif);
    chk("R3 start clears dav", dav_n, 1);
    repeat (7) @(negedge clk);
    chk("R1 dav before due edge", dav_n, 1);
    @(negedge clk);
    chk("R1 R3 dav at write", dav_n, 0);
    cnvt_n = 1'b1;
  endtask

  task automatic read_slot(input logic [3:0] idx, output logic [RES_W-1:0] val);
    rd_ch = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; val = rd_data;
  endtask

  task automatic convert(input logic [3:0] sel, input logic [3:0] slot, input logic dif,
                         input logic [RES_W-1:0] raw);
    model_raw[slot] = raw;
    run_direct(sel, slot, dif);
    read_slot(slot, got);
  endtask

  task automatic set_lim(input int k, input logic [RES_W-1:0] lo, input logic [RES_W-1:0] hi);
    lo_lim[k*RES_W +: RES_W] = lo;
    hi_lim[k*RES_W +: RES_W] = hi;
  endtask

  task automatic clear_all();
    @(negedge clk); alarm_clr = '1;
    @(negedge clk); alarm_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < CH_N; k++) begin
      model_raw[k] = '0;
      set_lim(k, 12'h000, 12'hFFF);
    end
    repeat (3) @(negedge clk);
    chk("R12 dav in reset", dav_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 dav", dav_n, 1);
    chk("R12 alarm", alarm_n, 1);
    chk("R12 status", alarm_sts, 0);
    chk("R12 start", conv_start, 0);
    read_slot(4'd7, got);
    chk("R12 R11 result zero", got, 0);

    // table walk: direct conversions, slot mapping, storage format
    for (int i = 0; i < 7; i++) begin
      logic [33:0] v;
      logic dif;
      v = VEC[i];
      diff_en = v[29:28];
      dif = (v[15:12] == 4'd0 && v[28]) || (v[15:12] == 4'd2 && v[29]);
      convert(v[33:30], v[15:12], dif, v[27:16]);
      chk("R7 R11 stored value", got, v[11:0]);
      chk("R3 read releases dav", dav_n, 1);
    end
    diff_en = 2'b00;

    // R2: retrigger during a conversion is ignored
    model_raw[6] = 12'h3C3;
    model_raw[9] = 12'h111;
    @(negedge clk); dir_sel = 4'd6; cnvt_n = 1'b0;
    repeat (4) @(negedge clk); cnvt_n = 1'b1;
    @(negedge clk); cnvt_n = 1'b0; dir_sel = 4'd9;
    repeat (4) @(negedge clk);
    chk("R2 dav before due edge", dav_n, 1);
    @(negedge clk);
    chk("R2 original finishes", dav_n, 0);
    chk("R2 slot unchanged", conv_ch, 6);
    cnvt_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 dav held without read", dav_n, 0);
    // new start releases dav
    @(negedge clk); dir_sel = 4'd6; cnvt_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 new start releases dav", dav_n, 1);
    repeat (8) @(negedge clk);
    chk("R3 second result", dav_n, 0);
    cnvt_n = 1'b1;
    read_slot(4'd6, got);
    chk("R11 slot 6", got, 12'h3C3);

    // limits, unsigned
    set_lim(5, 12'h100, 12'h200);
    alarm_en = 16'h0020;
    clear_all();
    convert(4'd5, 4'd5, 1'b0, 12'h180);
    chk("R8 in window", alarm_sts[5], 0);
    chk("R10 no alarm", alarm_n, 1);
    convert(4'd5, 4'd5, 1'b0, 12'h250);
    chk("R8 above upper", alarm_sts[5], 1);
    chk("R10 alarm low", alarm_n, 0);
    convert(4'd5, 4'd5, 1'b0, 12'h180);
    chk("R9 sticky", alarm_sts[5], 1);
    @(negedge clk); alarm_en = '0;
    @(negedge clk);
    chk("R10 masked", alarm_n, 1);
    alarm_en = 16'h0020;
    @(negedge clk); alarm_clr[5] = 1'b1;
    @(negedge clk); alarm_clr[5] = 1'b0;
    chk("R9 cleared", alarm_sts[5], 0);
    chk("R10 alarm released", alarm_n, 1);
    convert(4'd5, 4'd5, 1'b0, 12'h200);
    chk("R8 equal to limit", alarm_sts[5], 0);
    convert(4'd5, 4'd5, 1'b0, 12'h0FF);
    chk("R8 below lower", alarm_sts[5], 1);

    // limits, signed pair in slot 0: window -8..+8
    diff_en = 2'b01;
    set_lim(0, 12'hFF8, 12'h008);
    alarm_en = 16'h0001;
    clear_all();
    convert(4'd1, 4'd0, 1'b1, 12'h7FC);
    chk("R7 minus four", got, 12'hFFC);
    chk("R8 signed in window", alarm_sts[0], 0);
    convert(4'd0, 4'd0, 1'b1, 12'h900);
    chk("R7 plus 256", got, 12'h100);
    chk("R8 signed above", alarm_sts[0], 1);
    chk("R10 alarm slot 0", alarm_n, 0);
    diff_en = 2'b00;
    alarm_en = '0;

    // auto scan over 2, 5, 15 with a trigger edge that must be ignored
    @(negedge clk); ch_en = 16'h8024; mode_auto = 1'b1; cnvt_n = 1'b0;
    @(negedge clk);
    chk("R4 first slot", conv_ch, 2);
    chk("R4 start mark", conv_start, 1);
    repeat (8) @(negedge clk);
    chk("R4 R2 second slot", conv_ch, 5);
    repeat (8) @(negedge clk);
    chk("R4 third slot", conv_ch, 15);
    repeat (7) @(negedge clk);
    chk("R5 high before scan end", dav_n, 1);
    @(negedge clk);
    chk("R5 pulse start", dav_n, 0);
    chk("R4 wrap", conv_ch, 2);
    repeat (3) @(negedge clk);
    chk("R5 pulse last cycle", dav_n, 0);
    @(negedge clk);
    chk("R5 pulse end", dav_n, 1);
    mode_auto = 1'b0; cnvt_n = 1'b1;
    repeat (20) @(negedge clk);

    // auto scan with pair on 0/1 plus slot 8
    diff_en = 2'b01; ch_en = 16'h0103;
    @(negedge clk); mode_auto = 1'b1;
    @(negedge clk);
    chk("R6 pair slot", conv_ch, 0);
    chk("R6 pair flag", conv_diff, 1);
    repeat (8) @(negedge clk);
    chk("R6 partner skipped", conv_ch, 8);
    chk("R6 single flag", conv_diff, 0);
    repeat (8) @(negedge clk);
    chk("R4 wrap to pair", conv_ch, 0);
    chk("R5 pulse after slot 8", dav_n, 0);
    mode_auto = 1'b0;
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule